// File: doc/BRIEF.md
# Buzzer Tone Generator

This block drives one buzzer pin from a 32.768 kHz low-speed clock. While it runs, the pin carries a square wave. The tone period is one of eight whole-cycle divisors of that clock. The share of the period spent at the active level is set in sixteenths. A polarity bit picks whether the active level is high or low.

An envelope sits on top of the tone and gates it in fixed time slots, 62.5 ms each at the default parameter. Four sound modes are available:

- continuous tone;
- a single burst of two slots;
- a one-on, one-off beep;
- a double beep inside an eight-slot frame.

A one-cycle start pulse captures the mode, frequency, duty and polarity inputs and begins the sound. Pulsing start again during a sound restarts it with fresh settings. A stop pulse ends the sound at once. The busy output shows whether a sound is in progress.

Top module: `buzz_gen`

## Requirements
- R1: Frequency code f (0..7) gives a tone period N of 8, 10, 12, 14, 16, 24, 32 or 112 clock cycles; the tone phase p counts 0..N-1 from the first cycle after start.
- R2: The tone is active in cycle phase p exactly when 16·p < D·N, where D is the duty code (1..15 means D/16); duty code 0 behaves as code 1.
- R3: When polarity is 0 the active level is 1, and when it is 1 the output is inverted; while not busy, the output equals the live polarity input.
- R4: Mode 0 (repeat) sounds without interruption and stays busy until stopped or restarted.
- R5: Mode 1 (single) sounds for exactly 2·SLOT_CYC cycles after start; busy then drops and the output returns to the idle level.
- R6: Mode 2 (intermittent 1) counts slots of SLOT_CYC cycles from start, and lets the tone through only in even-numbered slots (on, off, on, off...).
- R7: Mode 3 (intermittent 2) repeats a frame of 8 slots and lets the tone through only in slots 0 and 2 of each frame.
- R8: A start pulse captures mode, frequency, duty and polarity; input changes while busy have no effect until the next start. A start during a sound restarts the phase and slot timing from zero.
- R9: A stop pulse clears busy in the next cycle. Stop wins over a start asserted in the same cycle.
- R10: Busy is 0 after reset and becomes 1 in the cycle after an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: capture settings and begin or restart a sound |
| stop | input | 1 | One-cycle pulse: end the sound |
| mode_sel | input | 2 | Sound mode: 0 repeat, 1 single, 2 intermittent 1, 3 intermittent 2 |
| freq_sel | input | 3 | Tone period code |
| duty_sel | input | 4 | Duty code in sixteenths |
| neg_pol | input | 1 | 1 inverts the output; also sets the idle level |
| busy | output | 1 | A sound is in progress |
| bz_out | output | 1 | Buzzer pin |

## Verification
The output is compared cycle by cycle against a model built from the requirements. The stimulus covers every frequency code, low, middle and extreme duty codes (including code 0), both polarities and all four modes, each over a full eight-slot frame. Short periods with small duty codes show the rounding of the duty compare. The long 112-cycle period separates correct phase wrapping from a stuck counter. The intermittent modes with unequal slot patterns show whether the slot counter advances and wraps at the right boundary. Directed runs change the inputs while a sound is in progress, restart a sound, stop a sound mid-tone and collide start with stop; each of these separates captured settings from live ones and checks the priority between the two pulses.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    localparam int TONE_CW = 7;
    localparam int SLOT_W = 3;
    localparam int SINGLE_SLOTS = 2;

    typedef enum logic [1:0] {
        SND_REPEAT = 2'd0,
        SND_SINGLE = 2'd1,
        SND_BEEP1  = 2'd2,
        SND_BEEP2  = 2'd3
    } snd_mode_e;

    typedef struct packed {
        snd_mode_e  mode;
        logic [2:0] fsel;
        logic [3:0] duty;
        logic       neg;
    } buzz_cfg_t;

    // tone period in clock cycles for each frequency code
    function automatic logic [TONE_CW-1:0] tone_div(input logic [2:0] sel);
        logic [TONE_CW-1:0] n;
        case (sel)
            3'd0:    n = TONE_CW'(8);
            3'd1:    n = TONE_CW'(10);
            3'd2:    n = TONE_CW'(12);
            3'd3:    n = TONE_CW'(14);
            3'd4:    n = TONE_CW'(16);
            3'd5:    n = TONE_CW'(24);
            3'd6:    n = TONE_CW'(32);
            default: n = TONE_CW'(112);
        endcase
        return n;
    endfunction

    // duty code 0 is clamped to the smallest step
    function automatic logic [3:0] duty_eff(input logic [3:0] d);
        return (d == 4'd0) ? 4'd1 : d;
    endfunction

    // envelope gate per mode and slot index
    function automatic logic slot_gate(input snd_mode_e m, input logic [SLOT_W-1:0] slot);
        logic g;
        case (m)
            SND_BEEP1: g = ~slot[0];
            SND_BEEP2: g = (slot == SLOT_W'(0)) || (slot == SLOT_W'(2));
            default:   g = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/buzz_tone.sv
module buzz_tone
    import buzz_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic [2:0]         fsel,
    input  logic [3:0]         duty,
    output logic               tone_on,
    output logic [TONE_CW-1:0] phase
);

    localparam int PW = TONE_CW + 4;

    logic [TONE_CW-1:0] period;
    logic [PW-1:0]      scaled_phase;
    logic [PW-1:0]      threshold;

    assign period = tone_div(fsel);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            phase <= '0;
        end else if (phase == period - TONE_CW'(1)) begin
            phase <= '0;
        end else begin
            phase <= phase + TONE_CW'(1);
        end
    end

    always_comb begin
        scaled_phase = {phase, 4'b0000};
        threshold    = PW'(duty_eff(duty)) * PW'(period);
        tone_on      = scaled_phase < threshold;
    end

endmodule

// File: rtl/buzz_envelope.sv
module buzz_envelope
    import buzz_pkg::*;
#(
    parameter int SLOT_CYC = 2048
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      stop,
    input  snd_mode_e mode,
    output logic      busy,
    output logic      gate
);

    localparam int SCW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

    logic [SCW-1:0]    scnt;
    logic [SLOT_W-1:0] slot;
    logic              slot_last;
    logic              single_end;

    assign slot_last  = (scnt == SCW'(SLOT_CYC - 1));
    assign single_end = busy && (mode == SND_SINGLE) && slot_last
                        && (slot == SLOT_W'(SINGLE_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst || start || !busy) begin
            scnt <= '0;
            slot <= '0;
        end else if (slot_last) begin
            scnt <= '0;
            slot <= slot + SLOT_W'(1);
        end else begin
            scnt <= scnt + SCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (single_end) begin
            busy <= 1'b0;
        end
    end

    assign gate = slot_gate(mode, slot);

endmodule

// File: rtl/buzz_gen.sv
module buzz_gen
    import buzz_pkg::*;
#(
    parameter int SLOT_CYC = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       stop,
    input  logic [1:0] mode_sel,
    input  logic [2:0] freq_sel,
    input  logic [3:0] duty_sel,
    input  logic       neg_pol,
    output logic       busy,
    output logic       bz_out
);

    buzz_cfg_t          cfg_q;
    logic               take;
    logic               gate;
    logic               tone_on;
    logic [TONE_CW-1:0] tone_phase;

    assign take = start && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= '{mode: snd_mode_e'(mode_sel), fsel: freq_sel,
                       duty: duty_sel, neg: neg_pol};
        end
    end

    buzz_envelope #(.SLOT_CYC(SLOT_CYC)) u_env (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stop  (stop),
        .mode  (cfg_q.mode),
        .busy  (busy),
        .gate  (gate)
    );

    buzz_tone u_tone (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (take),
        .fsel    (cfg_q.fsel),
        .duty    (cfg_q.duty),
        .tone_on (tone_on),
        .phase   (tone_phase)
    );

    assign bz_out = busy ? (cfg_q.neg ^ (gate & tone_on)) : neg_pol;

endmodule

// File: rtl/buzz_gen_chk.sv
module buzz_gen_chk
    import buzz_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               stop,
    input logic               neg_pol,
    input logic               busy,
    input logic               bz_out,
    input buzz_cfg_t          cfg,
    input logic [TONE_CW-1:0] phase
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bz_out == neg_pol));

    // R9
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);

    // R10
    start_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> busy);

    // R4
    sound_persists_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !stop && !start && cfg.mode != SND_SINGLE) |=> busy);

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> $stable(cfg));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase < tone_div(cfg.fsel));

endmodule

bind buzz_gen buzz_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .neg_pol (neg_pol),
    .busy    (busy),
    .bz_out  (bz_out),
    .cfg     (cfg_q),
    .phase   (tone_phase)
);

// File: tb/test_buzz_gen.sv
module test_buzz_gen;

    localparam int SLOT = 40;
    localparam int RUN_T = 8 * SLOT + 20;
    localparam int NVEC = 10;

    // {mode[1:0], freq[2:0], duty[3:0], pol}
    localparam logic [9:0] VECS [NVEC] = '{
        {2'd0, 3'd0, 4'd8,  1'b0},   // R1 R2 R4
        {2'd0, 3'd7, 4'd1,  1'b0},   // R1 R2 long period
        {2'd0, 3'd5, 4'd15, 1'b1},   // R2 R3 inverted
        {2'd0, 3'd1, 4'd0,  1'b0},   // R2 duty code 0
        {2'd1, 3'd2, 4'd4,  1'b0},   // R5 single
        {2'd2, 3'd3, 4'd12, 1'b0},   // R6
        {2'd3, 3'd4, 4'd6,  1'b1},   // R7 inverted
        {2'd3, 3'd6, 4'd10, 1'b0},   // R7
        {2'd2, 3'd7, 4'd3,  1'b1},   // R6 inverted
        {2'd0, 3'd3, 4'd5,  1'b0}    // R1 R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [1:0] mode_sel = '0;
    logic [2:0] freq_sel = '0;
    logic [3:0] duty_sel = '0;
    logic       neg_pol = 1'b0;
    logic       busy;
    logic       bz_out;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    buzz_gen #(.SLOT_CYC(SLOT)) i_buzz_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .mode_sel (mode_sel),
        .freq_sel (freq_sel),
        .duty_sel (duty_sel),
        .neg_pol  (neg_pol),
        .busy     (busy),
        .bz_out   (bz_out)
    );

    function automatic int ref_div(input int s);
        case (s)
            0: return 8;
            1: return 10;
            2: return 12;
            3: return 14;
            4: return 16;
            5: return 24;
            6: return 32;
            default: return 112;
        endcase
    endfunction

    // expected {busy, bz_out} at cycle t after an accepted start
    function automatic logic [1:0] ref_out(input int m, input int f, input int d,
                                           input int p, input int live, input int t);
        int  n, de, slot;
        bit  b, tone, g;
        b = (m == 1) ? (t < 2 * SLOT) : 1'b1;
        if (!b) return {1'b0, live[0]};
        n = ref_div(f);
        de = (d == 0) ? 1 : d;
        tone = ((t % n) * 16) < (de * n);
        slot = (t / SLOT) % 8;
        case (m)
            2: g = (slot % 2) == 0;
            3: g = (slot == 0) || (slot == 2);
            default: g = 1'b1;
        endcase
        return {1'b1, p[0] ^ (g & tone)};
    endfunction

    task automatic check1(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s got=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic run_vec(input int m, input int f, input int d, input int p,
                           input bit scramble, input bit end_stop, input string req);
        int bad_t;
        int live;
        logic [1:0] got, exp, bad_got, bad_exp;
        bad_t = -1;
        bad_got = '0;
        bad_exp = '0;
        @(negedge clk);
        mode_sel = 2'(m);
        freq_sel = 3'(f);
        duty_sel = 4'(d);
        neg_pol = p[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        live = p;
        if (scramble) begin
            mode_sel = 2'(3 - m);
            freq_sel = 3'(7 - f);
            duty_sel = 4'(15 - d);
            neg_pol = ~p[0];
            live = 1 - p;
        end
        for (int t = 0; t < RUN_T; t++) begin
            got = {busy, bz_out};
            exp = ref_out(m, f, d, p, live, t);
            if (got !== exp && bad_t < 0) begin
                bad_t = t;
                bad_got = got;
                bad_exp = exp;
            end
            @(negedge clk);
        end
        n_checks++;
        if (bad_t >= 0) begin
            n_fails++;
            $display("FAIL %s mode=%0d f=%0d d=%0d pol=%0d t=%0d {busy,out} got=%b expected=%b",
                     req, m, f, d, p, bad_t, bad_got, bad_exp);
        end
        if (end_stop) begin
            stop = 1'b1;
            @(negedge clk);
            stop = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state, R3 idle level
        check1("R10 busy after reset", busy, 1'b0);
        check1("R3 idle output pol=0", bz_out, 1'b0);
        neg_pol = 1'b1;
        #1;
        check1("R3 idle output pol=1", bz_out, 1'b1);
        neg_pol = 1'b0;

        // table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            run_vec(int'(VECS[i][9:8]), int'(VECS[i][7:5]), int'(VECS[i][4:1]),
                    int'(VECS[i][0]), 1'b0, 1'b1, "R1/R2/R3/R4/R5/R6/R7 table");
        end

        // R8 inputs changed during a sound are ignored
        run_vec(0, 2, 5, 0, 1'b1, 1'b1, "R8 inputs ignored while busy");

        // R8 restart during a sound: timing restarts from zero with new settings
        @(negedge clk);
        mode_sel = 2'd0; freq_sel = 3'd0; duty_sel = 4'd8; neg_pol = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (17) @(negedge clk);
        run_vec(2, 7, 1, 0, 1'b0, 1'b1, "R8 restart while busy");

        // R9 stop in the middle of a tone
        @(negedge clk);
        mode_sel = 2'd0; freq_sel = 3'd4; duty_sel = 4'd15; neg_pol = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check1("R9 busy after stop", busy, 1'b0);
        check1("R9 output at idle level after stop", bz_out, 1'b1);

        // R9 stop wins over start in the same cycle
        neg_pol = 1'b0;
        start = 1'b1;
        stop = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stop = 1'b0;
        check1("R9 stop beats start", busy, 1'b0);

        // R10 busy rises the cycle after start
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check1("R10 busy after start", busy, 1'b1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule